// File: doc/BRIEF.md
# Dual-Read Register File

This block is the architectural register store of a small single-cycle integer core. It holds 32 words of 32 bits and offers two read ports and one write port. The read ports work at the same time and independently of each other, so the decode stage can fetch both source operands in one cycle. The write port returns the result of the previous operation.

Writes land on the falling clock edge. A result that is set up early in a cycle is therefore already readable in the second half of that same cycle, with no forwarding path. Reads are purely combinational. Entry zero is a constant zero: any write aimed at it is dropped. An asynchronous active-low reset clears the store. Its release is synchronised to the write edge.

Top module: `rf_dual_read`

## Requirements
- R1: The store holds 32 independent 32-bit entries. A value written to one nonzero index is read back unchanged from that index, and writes to other indices do not alter it.
- R2: Index 0 always reads as 32'h0 on both ports, including after a write of any data to index 0.
- R3: Read port A returns the entry selected by `rd_idx_a` and read port B returns the entry selected by `rd_idx_b`. The two ports read at the same time, whether their indices are equal or different.
- R4: A write with `wr_en` = 1 takes effect on the falling clock edge. Before that edge a read of the written index returns the old value. After that edge, still within the same clock cycle, it returns the new value.
- R5: While `wr_en` = 0, no entry changes, whatever `wr_idx` and `wr_data` hold.
- R6: The read outputs follow a change of a read index without any clock edge.
- R7: Driving `rst_n` low clears every entry to zero at once, without a clock. After `rst_n` returns high, a write at the first falling edge is ignored; from the third falling edge on, writes take effect.
- R8: A write to index 0 with `wr_en` = 1 leaves all 32 entries unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; entries are written on its falling edge |
| rst_n | input | 1 | Asynchronous active-low reset, released on the falling edge |
| wr_en | input | 1 | Write enable, active high |
| wr_idx | input | 5 | Index of the entry to write |
| wr_data | input | 32 | Data to write |
| rd_idx_a | input | 5 | Index read on port A |
| rd_idx_b | input | 5 | Index read on port B |
| rd_data_a | output | 32 | Contents of the entry at `rd_idx_a` |
| rd_data_b | output | 32 | Contents of the entry at `rd_idx_b` |

## Verification
A read is due within the same time step as its index change. The bench therefore samples one time unit after each index change, with no clock edge in between. A write is due just after the falling edge that follows its setup. The bench drives the write one unit after a rising edge, checks the old value before the falling edge, and checks the new value one unit after it. The reset-release window is counted in falling edges: the bench tries a write at the first edge after release and expects it to be dropped.

// File: rtl/rf_pkg.sv
package rf_pkg;
  localparam int RF_DEPTH_DEF = 32;
  localparam int RF_WIDTH_DEF = 32;
  localparam int RF_SYNC_DEF  = 2;
endpackage

// File: rtl/rf_reset_sync.sv
module rf_reset_sync #(
  parameter int STAGES = rf_pkg::RF_SYNC_DEF
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_nxt;

  always_comb begin
    chain_nxt = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_nxt;
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/rf_wr_decode.sv
module rf_wr_decode #(
  parameter int DEPTH = rf_pkg::RF_DEPTH_DEF,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  output logic [DEPTH-1:1] load
);
  always_comb begin
    for (int i = 1; i < DEPTH; i++) begin
      load[i] = wr_en && (wr_idx == IDX_W'(i));
    end
  end
endmodule

// File: rtl/rf_entry.sv
module rf_entry #(
  parameter int WIDTH = rf_pkg::RF_WIDTH_DEF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] val_q;
  logic [WIDTH-1:0] val_nxt;

  always_comb begin
    val_nxt = val_q;
    if (load) val_nxt = d;
  end

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) val_q <= '0;
    else        val_q <= val_nxt;
  end

  assign q = val_q;
endmodule

// File: rtl/rf_rd_mux.sv
module rf_rd_mux #(
  parameter int DEPTH = rf_pkg::RF_DEPTH_DEF,
  parameter int WIDTH = rf_pkg::RF_WIDTH_DEF,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic [DEPTH-1:0][WIDTH-1:0] bank,
  input  logic [IDX_W-1:0]            idx,
  output logic [WIDTH-1:0]            data
);
  always_comb begin
    data = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (idx == IDX_W'(i)) data = bank[i];
    end
  end
endmodule

// File: rtl/rf_dual_read.sv
module rf_dual_read #(
  parameter int DEPTH  = rf_pkg::RF_DEPTH_DEF,
  parameter int WIDTH  = rf_pkg::RF_WIDTH_DEF,
  parameter int STAGES = rf_pkg::RF_SYNC_DEF,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [WIDTH-1:0] wr_data,
  input  logic [IDX_W-1:0] rd_idx_a,
  input  logic [IDX_W-1:0] rd_idx_b,
  output logic [WIDTH-1:0] rd_data_a,
  output logic [WIDTH-1:0] rd_data_b
);
  logic                        rst_core_n;
  logic [DEPTH-1:1]            load;
  logic [DEPTH-1:0][WIDTH-1:0] bank;

  rf_reset_sync #(.STAGES(STAGES)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_core_n)
  );

  rf_wr_decode #(.DEPTH(DEPTH)) u_dec (
    .wr_en(wr_en), .wr_idx(wr_idx), .load(load)
  );

  assign bank[0] = '0;

  for (genvar g = 1; g < DEPTH; g++) begin : g_entry
    rf_entry #(.WIDTH(WIDTH)) u_entry (
      .clk(clk), .rst_n(rst_core_n), .load(load[g]),
      .d(wr_data), .q(bank[g])
    );
  end

  rf_rd_mux #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_rd_a (
    .bank(bank), .idx(rd_idx_a), .data(rd_data_a)
  );

  rf_rd_mux #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_rd_b (
    .bank(bank), .idx(rd_idx_b), .data(rd_data_b)
  );
endmodule

// File: rtl/rf_dual_read_chk.sv
module rf_dual_read_chk #(
  parameter int DEPTH = rf_pkg::RF_DEPTH_DEF,
  parameter int WIDTH = rf_pkg::RF_WIDTH_DEF,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input logic             clk,
  input logic             rst_core_n,
  input logic             wr_en,
  input logic [IDX_W-1:0] wr_idx,
  input logic [WIDTH-1:0] wr_data,
  input logic [IDX_W-1:0] rd_idx_a,
  input logic [IDX_W-1:0] rd_idx_b,
  input logic [WIDTH-1:0] rd_data_a,
  input logic [WIDTH-1:0] rd_data_b
);
  logic [DEPTH-1:0][WIDTH-1:0] shadow;

  always_ff @(negedge clk or negedge rst_core_n) begin
    if (!rst_core_n) shadow <= '0;
    else if (wr_en && wr_idx != '0) shadow[wr_idx] <= wr_data;
  end

  AST_PORT_A_MATCH: assert property (@(posedge clk) disable iff (!rst_core_n)
    rd_data_a == shadow[rd_idx_a]) else $error("port A mismatch"); // R3
  AST_PORT_B_MATCH: assert property (@(posedge clk) disable iff (!rst_core_n)
    rd_data_b == shadow[rd_idx_b]) else $error("port B mismatch"); // R3
  AST_ZERO_A: assert property (@(posedge clk) disable iff (!rst_core_n)
    rd_idx_a == '0 |-> rd_data_a == '0) else $error("index 0 nonzero on A"); // R2
  AST_ZERO_B: assert property (@(posedge clk) disable iff (!rst_core_n)
    rd_idx_b == '0 |-> rd_data_b == '0) else $error("index 0 nonzero on B"); // R2

  always @(posedge clk) begin
    if (!rst_core_n) begin
      AST_RESET_EMPTY: assert (rd_data_a == '0 && rd_data_b == '0)
        else $error("store not empty in reset"); // R7
    end
  end
endmodule

bind rf_dual_read rf_dual_read_chk #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_chk (
  .clk(clk), .rst_core_n(rst_core_n), .wr_en(wr_en), .wr_idx(wr_idx),
  .wr_data(wr_data), .rd_idx_a(rd_idx_a), .rd_idx_b(rd_idx_b),
  .rd_data_a(rd_data_a), .rd_data_b(rd_data_b)
);

// File: tb/test_rf_dual_read.sv
module test_rf_dual_read;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b1;
  logic        wr_en = 1'b0;
  logic [4:0]  wr_idx = '0;
  logic [31:0] wr_data = '0;
  logic [4:0]  rd_idx_a = '0;
  logic [4:0]  rd_idx_b = '0;
  logic [31:0] rd_data_a, rd_data_b;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;
  logic [31:0] model [32];

  rf_dual_read i_rf_dual_read (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .rd_idx_a(rd_idx_a), .rd_idx_b(rd_idx_b),
    .rd_data_a(rd_data_a), .rd_data_b(rd_data_b)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [31:0] pat(int i, int r);
    return (32'(i) * 32'h0101_0101) ^ (r == 0 ? 32'h5A5A_3C3C : 32'hDEAD_BEEF) ^ (32'(i) << 27);
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic rd_both(string req, int a, int b);
    rd_idx_a = 5'(a);
    rd_idx_b = 5'(b);
    #1;
    chk(req, rd_data_a, model[a]);
    chk(req, rd_data_b, model[b]);
  endtask

  task automatic write(logic en, int idx, logic [31:0] d);
    @(posedge clk); #1;
    wr_en = en; wr_idx = 5'(idx); wr_data = d;
    @(negedge clk); #1;
    if (en && idx != 0) model[idx] = d;
    wr_en = 1'b0;
  endtask

  task automatic sweep(string req);
    for (int i = 0; i < 32; i++) rd_both(req, i, 31 - i);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 32; i++) model[i] = '0;
    #1 rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    sweep("R7 reset state");

    // release, then write at first falling edge: dropped
    @(posedge clk); #1;
    rst_n = 1'b1;
    wr_en = 1'b1; wr_idx = 5'd5; wr_data = 32'hCAFE_0005;
    @(negedge clk); #1;
    wr_en = 1'b0;
    rd_both("R7 write after release ignored", 5, 0);
    repeat (3) @(posedge clk);

    // R4 falling-edge commit, same-cycle visibility
    rd_idx_a = 5'd7; rd_idx_b = 5'd7;
    @(posedge clk); #1;
    wr_en = 1'b1; wr_idx = 5'd7; wr_data = 32'h1234_5678;
    #1;
    chk("R4 old value before falling edge", rd_data_a, 32'h0);
    @(negedge clk); #1;
    model[7] = 32'h1234_5678;
    wr_en = 1'b0;
    chk("R4 new value after falling edge A", rd_data_a, model[7]);
    chk("R4 new value after falling edge B", rd_data_b, model[7]);

    // R1 fill and sweep, R2 index 0, R3 distinct ports
    for (int i = 1; i < 32; i++) write(1'b1, i, pat(i, 0));
    sweep("R1 R3 fill sweep");
    for (int i = 0; i < 32; i++) rd_both("R3 same index on both ports", i, i);

    // R5 enable low
    for (int i = 0; i < 32; i += 5) write(1'b0, i, ~pat(i, 0));
    sweep("R5 enable low leaves store");

    // R8 and R2 write to index 0
    write(1'b1, 0, 32'hFFFF_FFFF);
    rd_both("R2 index 0 after write", 0, 0);
    sweep("R8 write to index 0 no change");

    // R6 combinational reads within one half cycle
    @(posedge clk); #1;
    for (int i = 3; i < 32; i += 7) rd_both("R6 index change without clock", i, 31 - i);

    // R1 overwrite with second pattern
    for (int i = 1; i < 32; i++) write(1'b1, i, pat(i, 1));
    sweep("R1 overwrite sweep");

    // R7 asynchronous clear mid-cycle
    @(posedge clk); #2;
    rst_n = 1'b0;
    for (int i = 0; i < 32; i++) model[i] = '0;
    rd_both("R7 async clear", 9, 30);
    repeat (2) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);
    write(1'b1, 12, 32'h0BAD_F00D);
    rd_both("R7 write after reset window", 12, 11);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule